// File: doc/BRIEF.md
# Serial and Pin Configuration Front End for a Dual Lowpass Filter

This block holds the configuration of a two-channel programmable lowpass filter: one gain code that both channels share, a cutoff code, a shutdown request and one general-purpose output bit. A strap input chooses where that configuration comes from. With the strap low, the block acts as a write-only serial slave. An 8-bit byte is shifted in under chip select and is committed to a control latch when chip select rises. The bits that leave the shift register are presented on a serial output that is always driven, so several devices can share clock and select lines with each output feeding the next device's data input. With the strap high, the gain and cutoff codes are read directly from four control pins.

Two pins have a role in each mode. The select and serial-clock pins carry the two cutoff-code bits in pin mode. The low gain bit is an input in pin mode and, in serial mode, an output that drives the general-purpose bit of the latch. All asynchronous pins are brought into the system clock through two-flop synchronizers, and the serial logic acts only on the edges it detects there. The serial pins must therefore stay stable for a few system clocks between transitions.

Top module: `filt_cfg_ctrl`

## Requirements
- R1: After reset, the gain selection is 0 dB (gain_sel = 4'b0001), the bandwidth selection is the lowest (bw_sel = 3'b001), shutdown is 0, gain0_out is 0, sdo is 0, and the shift register and control latch hold 8'h00.
- R2: In serial mode (ser_mode_n = 0), each detected rising edge of ctl_b while ctl_a (active-low select) is low shifts sdi into bit 0 of an 8-bit shift register, so the first bit sent ends up in bit 7. A detected rising edge of ctl_a copies all 8 bits into the control latch.
- R3: Latch fields: bit 7 is gain code bit 0, bit 6 is gain code bit 1, bit 5 is cutoff code bit 0, bit 4 is cutoff code bit 1, bits 3..2 are ignored, bit 1 is shutdown and bit 0 is the general-purpose output.
- R4: The gain code {g1,g0} is decoded one-hot into gain_sel: bit 0 is 0 dB, bit 1 is 6 dB, bit 2 is 12 dB and bit 3 is 24 dB (gain_sel = 1 << code).
- R5: The cutoff code {c1,c0} is decoded one-hot into bw_sel: 00 gives bit 0 (lowest bandwidth), 01 gives bit 1 (four times the lowest), and 10 or 11 give bit 2 (sixteen times the lowest).
- R6: On each detected falling edge of ctl_b with ctl_a low, sdo takes the current bit 7 of the shift register. Before the k-th rising edge of a frame, sdo therefore shows bit 8-k of the byte that the shift register held when the frame began.
- R7: sdo changes only on those falling edges. It keeps its last value while ctl_a is high.
- R8: Edges on ctl_b while ctl_a is high leave the shift register unchanged. The decoded outputs change only when ctl_a rises, and never in the middle of a frame.
- R9: In pin mode (ser_mode_n = 1), the gain code is {gain1_pin, gain0_in} and the cutoff code is {ctl_a, ctl_b}. Shutdown is forced to 0, and activity on the pins does not change the control latch, which applies again when serial mode returns.
- R10: In serial mode gain0_oe is 1 and gain0_out equals latch bit 0. In pin mode gain0_oe is 0.
- R11: In serial mode, shutdown equals latch bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_mode_n | input | 1 | Mode strap: 0 selects serial mode, 1 selects pin mode |
| ctl_a | input | 1 | Active-low chip select in serial mode; cutoff code bit 1 in pin mode |
| ctl_b | input | 1 | Serial clock in serial mode; cutoff code bit 0 in pin mode |
| sdi | input | 1 | Serial data in |
| gain1_pin | input | 1 | Gain code bit 1 in pin mode |
| gain0_in | input | 1 | Input side of the shared gain-0 pin |
| sdo | output | 1 | Serial data out, always driven |
| gain0_out | output | 1 | Output side of the shared gain-0 pin (general-purpose bit) |
| gain0_oe | output | 1 | Output enable for the shared gain-0 pin |
| gain_sel | output | 4 | One-hot gain selection for both channels |
| bw_sel | output | 3 | One-hot cutoff selection |
| shutdown | output | 1 | Low-power shutdown request |

## Verification
Every one of the 256 byte values is sent in turn. This checks each field position and both decoders against arithmetic expectations. Because each frame also replays the byte sent before it on sdo, the sweep shows that the serial output order and the daisy-chain behaviour are correct for every bit pattern. A burst of serial-clock toggles with select high, followed by one more frame, separates a shift register that ignores those edges from one that takes them in. Sweeping all 16 pin-mode combinations while the latch holds shutdown set shows that pin-mode codes replace the latch fields and that shutdown is forced off. Returning to serial mode then shows that the latch was kept.

// File: rtl/fcfg_pkg.sv
package fcfg_pkg;

    localparam int CTRL_W      = 8;
    localparam int CODE_W      = 2;
    localparam int GAIN_LEVELS = 1 << CODE_W;
    localparam int BW_LEVELS   = 3;

    // Field positions inside the control byte; neighbours decode these.
    localparam int POS_GAIN0 = 7;
    localparam int POS_GAIN1 = 6;
    localparam int POS_LPF0  = 5;
    localparam int POS_LPF1  = 4;
    localparam int POS_SHDN  = 1;
    localparam int POS_GPO   = 0;

    typedef logic [CTRL_W-1:0] ctrl_byte_t;

    typedef struct packed {
        logic [CODE_W-1:0] gain_code;
        logic [CODE_W-1:0] bw_code;
        logic              shdn;
        logic              gpo;
    } cfg_t;

endpackage

// File: rtl/fcfg_sync.sv
module fcfg_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/fcfg_serial_core.sv
module fcfg_serial_core
    import fcfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic serial_en,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic sdo,
    output cfg_t cfg
);

    typedef struct packed {
        logic       cs_prev;
        logic       sclk_prev;
        ctrl_byte_t shreg;
        ctrl_byte_t ctrl;
        logic       sdo;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     cs_rise;
    logic     sclk_rise;
    logic     sclk_fall;

    always_comb begin
        cs_rise   = serial_en &  cs_n & ~st_q.cs_prev;
        sclk_rise = serial_en & ~cs_n &  sclk & ~st_q.sclk_prev;
        sclk_fall = serial_en & ~cs_n & ~sclk &  st_q.sclk_prev;

        st_d           = st_q;
        st_d.cs_prev   = cs_n;
        st_d.sclk_prev = sclk;
        if (sclk_rise) begin
            st_d.shreg = {st_q.shreg[CTRL_W-2:0], sdi};
        end
        if (sclk_fall) begin
            st_d.sdo = st_q.shreg[CTRL_W-1];
        end
        if (cs_rise) begin
            st_d.ctrl = st_q.shreg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cs_prev   <= 1'b1;
            st_q.sclk_prev <= 1'b0;
            st_q.shreg     <= '0;
            st_q.ctrl      <= '0;
            st_q.sdo       <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo           = st_q.sdo;
    assign cfg.gain_code = {st_q.ctrl[POS_GAIN1], st_q.ctrl[POS_GAIN0]};
    assign cfg.bw_code   = {st_q.ctrl[POS_LPF1], st_q.ctrl[POS_LPF0]};
    assign cfg.shdn      = st_q.ctrl[POS_SHDN];
    assign cfg.gpo       = st_q.ctrl[POS_GPO];

    // R8
    latch_on_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl != $past(st_q.ctrl)) |-> $past(cs_rise));

    // R2
    shift_on_sclk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.shreg != $past(st_q.shreg)) |-> $past(sclk_rise));

    // R2
    shift_takes_sdi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sclk_rise) |-> (st_q.shreg[0] == $past(sdi)));

    // R7
    sdo_on_sclk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sdo != $past(st_q.sdo)) |-> $past(sclk_fall));

endmodule

// File: rtl/fcfg_decode.sv
module fcfg_decode
    import fcfg_pkg::*;
(
    input  logic                   pin_mode,
    input  cfg_t                   ser_cfg,
    input  logic [CODE_W-1:0]      pin_gain,
    input  logic [CODE_W-1:0]      pin_bw,
    output logic [GAIN_LEVELS-1:0] gain_sel,
    output logic [BW_LEVELS-1:0]   bw_sel,
    output logic                   shdn,
    output logic                   gpo_out,
    output logic                   gpo_oe
);

    logic [CODE_W-1:0] gain_code;
    logic [CODE_W-1:0] bw_code;

    always_comb begin
        gain_code = pin_mode ? pin_gain : ser_cfg.gain_code;
        bw_code   = pin_mode ? pin_bw   : ser_cfg.bw_code;
        shdn      = ~pin_mode & ser_cfg.shdn;
        gpo_out   = ~pin_mode & ser_cfg.gpo;
        gpo_oe    = ~pin_mode;
    end

    for (genvar g = 0; g < GAIN_LEVELS; g++) begin : g_gain
        assign gain_sel[g] = (gain_code == CODE_W'(g));
    end

    // The top level saturates: every code at or above it selects the widest band.
    for (genvar b = 0; b < BW_LEVELS; b++) begin : g_bw
        if (b == BW_LEVELS - 1) begin : g_top
            assign bw_sel[b] = (bw_code >= CODE_W'(b));
        end else begin : g_lvl
            assign bw_sel[b] = (bw_code == CODE_W'(b));
        end
    end

endmodule

// File: rtl/filt_cfg_ctrl.sv
module filt_cfg_ctrl
    import fcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ser_mode_n,
    input  logic                   ctl_a,
    input  logic                   ctl_b,
    input  logic                   sdi,
    input  logic                   gain1_pin,
    input  logic                   gain0_in,
    output logic                   sdo,
    output logic                   gain0_out,
    output logic                   gain0_oe,
    output logic [GAIN_LEVELS-1:0] gain_sel,
    output logic [BW_LEVELS-1:0]   bw_sel,
    output logic                   shutdown
);

    localparam int          NSYNC    = 6;
    localparam logic [5:0]  SYNC_RST = 6'b010000;

    logic [NSYNC-1:0] raw_v;
    logic [NSYNC-1:0] syn_v;
    logic mode_s, a_s, b_s, sdi_s, g1_s, g0_s;
    logic pin_mode;
    cfg_t ser_cfg;

    assign raw_v = {ser_mode_n, ctl_a, ctl_b, sdi, gain1_pin, gain0_in};
    assign {mode_s, a_s, b_s, sdi_s, g1_s, g0_s} = syn_v;
    assign pin_mode = mode_s;

    fcfg_sync #(
        .W       (NSYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_v),
        .q     (syn_v)
    );

    fcfg_serial_core core_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .serial_en (~pin_mode),
        .cs_n      (a_s),
        .sclk      (b_s),
        .sdi       (sdi_s),
        .sdo       (sdo),
        .cfg       (ser_cfg)
    );

    fcfg_decode dec_i (
        .pin_mode (pin_mode),
        .ser_cfg  (ser_cfg),
        .pin_gain ({g1_s, g0_s}),
        .pin_bw   ({a_s, b_s}),
        .gain_sel (gain_sel),
        .bw_sel   (bw_sel),
        .shdn     (shutdown),
        .gpo_out  (gain0_out),
        .gpo_oe   (gain0_oe)
    );

    // R9
    pin_mode_no_shdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_mode |-> (!shutdown && !gain0_oe));

    // R4
    gain_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gain_sel) == 1);

    // R5
    bw_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bw_sel) == 1);

    // R10
    gpo_follows_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_mode |-> (gain0_oe && gain0_out == ser_cfg.gpo));

endmodule

// File: tb/filt_cfg_ctrl_tb_top.sv
module filt_cfg_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 6;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ser_mode_n, ctl_a, ctl_b, sdi, gain1_pin, gain0_in;
    logic       sdo, gain0_out, gain0_oe, shutdown;
    logic [3:0] gain_sel;
    logic [2:0] bw_sel;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 0;
    logic [7:0] held;
    logic [7:0] latched;

    always #(CLK_PERIOD/2) clk = ~clk;

    filt_cfg_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_mode_n (ser_mode_n),
        .ctl_a      (ctl_a),
        .ctl_b      (ctl_b),
        .sdi        (sdi),
        .gain1_pin  (gain1_pin),
        .gain0_in   (gain0_in),
        .sdo        (sdo),
        .gain0_out  (gain0_out),
        .gain0_oe   (gain0_oe),
        .gain_sel   (gain_sel),
        .bw_sel     (bw_sel),
        .shutdown   (shutdown)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [3:0] gain_exp(input logic [1:0] code);
        return 4'b0001 << code;
    endfunction

    function automatic logic [2:0] bw_exp(input logic [1:0] code);
        if (code == 2'd0) return 3'b001;
        if (code == 2'd1) return 3'b010;
        return 3'b100;
    endfunction

    task automatic check_latched(input logic [7:0] b, input string ctx);
        chk({"R3 R4 gain ", ctx}, {4'd0, gain_sel}, {4'd0, gain_exp({b[6], b[7]})});
        chk({"R3 R5 bw ", ctx},   {5'd0, bw_sel},   {5'd0, bw_exp({b[4], b[5]})});
        chk({"R11 shutdown ", ctx}, {7'd0, shutdown}, {7'd0, b[1]});
        chk({"R10 gpo ", ctx}, {6'd0, gain0_oe, gain0_out}, {6'd0, 1'b1, b[0]});
    endtask

    task automatic frame(input logic [7:0] b);
        ctl_a = 1'b0;
        settle();
        for (int i = 7; i >= 0; i--) begin
            sdi = b[i];
            settle();
            chk("R6 sdo replays held byte", {7'd0, sdo}, {7'd0, held[i]});
            ctl_b = 1'b1;
            settle();
            ctl_b = 1'b0;
            settle();
        end
        check_latched(latched, "R8 unchanged before select rises");
        ctl_a = 1'b1;
        settle();
        held    = b;
        latched = b;
        check_latched(b, "R2 after commit");
        chk("R7 sdo after select rises", {7'd0, sdo}, {7'd0, b[7]});
    endtask

    initial begin
        rst_n = 1'b0;
        ser_mode_n = 1'b0; ctl_a = 1'b1; ctl_b = 1'b0; sdi = 1'b0;
        gain1_pin = 1'b0; gain0_in = 1'b0;
        held = 8'h00; latched = 8'h00;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R1 reset state
        chk("R1 gain_sel", {4'd0, gain_sel}, 8'h01);
        chk("R1 bw_sel", {5'd0, bw_sel}, 8'h01);
        chk("R1 shutdown", {7'd0, shutdown}, 8'h00);
        chk("R1 gain0_out", {7'd0, gain0_out}, 8'h00);
        chk("R1 sdo", {7'd0, sdo}, 8'h00);

        // R2 R3 R4 R5 R6 R10 R11: every byte value
        for (int v = 0; v < 256; v++) begin
            frame(8'(v));
        end

        // R7 R8: serial clock edges with select high are ignored
        ctl_a = 1'b1;
        for (int k = 0; k < 5; k++) begin
            sdi = ~sdi;
            ctl_b = 1'b1;
            settle();
            chk("R7 sdo holds while deselected", {7'd0, sdo}, {7'd0, held[7]});
            ctl_b = 1'b0;
            settle();
            check_latched(latched, "R8 deselected clocks");
        end
        frame(8'h36);

        // R9: pin mode, latch holds shutdown set
        ser_mode_n = 1'b1;
        settle();
        for (int p = 0; p < 16; p++) begin
            {ctl_a, ctl_b, gain1_pin, gain0_in} = 4'(p);
            settle();
            chk("R9 pin gain", {4'd0, gain_sel}, {4'd0, gain_exp(2'(p & 3))});
            chk("R9 pin bw", {5'd0, bw_sel}, {5'd0, bw_exp(2'(p >> 2))});
            chk("R9 shutdown forced off", {7'd0, shutdown}, 8'h00);
            chk("R10 pin mode oe", {7'd0, gain0_oe}, 8'h00);
        end
        ctl_a = 1'b1; ctl_b = 1'b0;
        settle();
        ser_mode_n = 1'b0;
        settle();
        check_latched(8'h36, "R9 latch kept across pin mode");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired before the test completed");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule